// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block is the host-bridge register that places the memory-mapped PCI Express configuration window in the system address map. Software writes a 64-bit base register through a dword-wide configuration-write port with byte enables. From the stored value the block derives three things: whether the window is on, its base address, and its length of 256 MB, 128 MB or 64 MB. The length code also decides which low base-address bits are honoured.

Each incoming memory address is compared against the window. One cycle later the block reports whether the address hit. On a hit it also gives the bus, device, function and register offset carried by the address's distance from the window base. A reserved length code turns the window off no matter what the enable bit holds. The decode follows the stored register directly, so reset and every write that touches the register take effect together.

Top module: `ecw_window_dec`

## Requirements
- R1: After reset the stored register reads 0x00000000_B0000000. The decode then gives window off, base 0xB000_0000 and length 256 MB (0x1000_0000).
- R2: The register occupies configuration dword indices 0x18 (register bits 31:0, byte offset 0x60) and 0x19 (bits 63:32). Byte enable bit i updates only byte i of the addressed dword. Writes to any other dword index, or with no byte enable set, leave the register unchanged. The stored value is readable on `bar_value`, and the decode follows it from the cycle after the write.
- R3: Register bit 0 enables the window. When it is clear, no address hits.
- R4: Register bits 2:1 select the length: 00 selects 256 MB, 01 selects 128 MB, and 10 selects 64 MB.
- R5: The base address always takes register bits 35:28. With code 01 it also takes bits 27:26, and with code 10 it takes bits 27:25. All other register bits are treated as zero in the base, including bits 63:36.
- R6: Length code 11 is reserved. It forces the window off with length zero, even when bit 0 is set.
- R7: A sample on `mem_valid` gives `hit_valid` one cycle later. `hit` is then 1 exactly when the window is on and base <= address < base + length.
- R8: On a hit the offset (address minus base) is output as bus = offset[27:20], device = offset[19:15], function = offset[14:12] and register = offset[11:0]. On a miss all four fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dw | input | 6 | Dword index in configuration space |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data |
| bar_value | output | 64 | Stored base register |
| win_en | output | 1 | Window is enabled |
| win_base | output | 36 | Decoded window base |
| win_len | output | 29 | Window length in bytes |
| mem_valid | input | 1 | Memory address is valid |
| mem_addr | input | 36 | Memory address to test |
| hit_valid | output | 1 | Result of last sampled address is present |
| hit | output | 1 | Address fell inside the window |
| hit_bus | output | 8 | Bus number from offset |
| hit_dev | output | 5 | Device number from offset |
| hit_fn | output | 3 | Function number from offset |
| hit_reg | output | 12 | Register offset |

## Verification
The assertions check several properties on every cycle:
- the register stays stable without a write, and after writes to unrelated dwords;
- the reserved length code keeps the window off and its length at zero;
- the base carries no bits below those the length code allows;
- the length is a single power of two;
- `hit_valid` tracks `mem_valid` one cycle late;
- a miss leaves the offset fields at zero;
- a disabled window produces no hit.

Only the bench scenarios show the window boundaries at base and base + length - 1 for each length, the exact offset split, byte-lane merging, and the dropping of bits 63:36.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
  // Byte offset of the base register in configuration space.
  localparam logic [7:0] BAR_CFG_OFS = 8'h60;
  localparam logic [63:0] BAR_RST_VAL = 64'h0000_0000_B000_0000;

  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSVD = 2'b11
  } win_len_e;
endpackage

// File: rtl/ecw_bar_reg.sv
module ecw_bar_reg #(
  parameter int CFG_DW_W = 6,
  parameter logic [CFG_DW_W-1:0] BAR_DW = CFG_DW_W'(6'h18),
  parameter logic [63:0] RST_VAL = 64'h0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CFG_DW_W-1:0] wr_dw,
  input  logic [3:0]          wr_be,
  input  logic [31:0]         wr_data,
  output logic [63:0]         bar_q
);
  localparam int NBYTES = 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    localparam logic [CFG_DW_W-1:0] LANE_DW = BAR_DW + CFG_DW_W'(b / 4);
    localparam int LANE = b % 4;
    logic       lane_we;
    logic [7:0] lane_d;

    always_comb begin
      lane_we = wr_en && (wr_dw == LANE_DW) && wr_be[LANE];
      lane_d  = wr_data[8*LANE +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bar_q[8*b +: 8] <= RST_VAL[8*b +: 8];
      else if (lane_we) bar_q[8*b +: 8] <= lane_d;
    end
  end
endmodule

// File: rtl/ecw_field_decode.sv
module ecw_field_decode
  import ecw_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int WIN_LOG2 = 28
) (
  input  logic [ADDR_W-1:0] bar,
  output logic              en,
  output logic [ADDR_W-1:0] base,
  output logic [WIN_LOG2:0] len
);
  localparam int LEN_W = WIN_LOG2 + 1;

  win_len_e          code;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    code = win_len_e'(bar[2:1]);
    en   = bar[0];
    mask = '0;
    mask[ADDR_W-1:WIN_LOG2] = '1;
    len  = '0;
    case (code)
      LEN_256M: len = LEN_W'(1) << WIN_LOG2;
      LEN_128M: begin
        len = LEN_W'(1) << (WIN_LOG2 - 1);
        mask[WIN_LOG2-1] = 1'b1;
        mask[WIN_LOG2-2] = 1'b1;
      end
      LEN_64M: begin
        len = LEN_W'(1) << (WIN_LOG2 - 2);
        mask[WIN_LOG2-1] = 1'b1;
        mask[WIN_LOG2-2] = 1'b1;
        mask[WIN_LOG2-3] = 1'b1;
      end
      default: en = 1'b0;
    endcase
    base = bar & mask;
  end
endmodule

// File: rtl/ecw_addr_match.sv
module ecw_addr_match #(
  parameter int ADDR_W   = 36,
  parameter int WIN_LOG2 = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mem_valid,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic                en,
  input  logic [ADDR_W-1:0]   base,
  input  logic [WIN_LOG2:0]   len,
  output logic                hit_valid_q,
  output logic                hit_q,
  output logic [WIN_LOG2-1:0] off_q
);
  logic [ADDR_W:0]     diff;
  logic                in_win;
  logic                hit_d;
  logic [WIN_LOG2-1:0] off_d;

  always_comb begin
    diff   = {1'b0, mem_addr} - {1'b0, base};
    in_win = en && !diff[ADDR_W] && (diff[ADDR_W-1:0] < ADDR_W'(len));
    hit_d  = in_win;
    off_d  = in_win ? diff[WIN_LOG2-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_valid_q <= 1'b0;
    else        hit_valid_q <= mem_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      off_q <= '0;
    end else if (mem_valid) begin
      hit_q <= hit_d;
      off_q <= off_d;
    end
  end
endmodule

// File: rtl/ecw_window_dec.sv
module ecw_window_dec
  import ecw_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int WIN_LOG2 = 28,
  parameter int CFG_DW_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [CFG_DW_W-1:0]  cfg_wr_dw,
  input  logic [3:0]           cfg_wr_be,
  input  logic [31:0]          cfg_wr_data,
  output logic [63:0]          bar_value,
  output logic                 win_en,
  output logic [ADDR_W-1:0]    win_base,
  output logic [WIN_LOG2:0]    win_len,
  input  logic                 mem_valid,
  input  logic [ADDR_W-1:0]    mem_addr,
  output logic                 hit_valid,
  output logic                 hit,
  output logic [WIN_LOG2-21:0] hit_bus,
  output logic [4:0]           hit_dev,
  output logic [2:0]           hit_fn,
  output logic [11:0]          hit_reg
);
  localparam logic [CFG_DW_W-1:0] BAR_DW = CFG_DW_W'(BAR_CFG_OFS >> 2);

  logic [63:0]         bar_q;
  logic [WIN_LOG2-1:0] off_q;

  ecw_bar_reg #(.CFG_DW_W(CFG_DW_W), .BAR_DW(BAR_DW), .RST_VAL(BAR_RST_VAL)) u_bar (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_dw(cfg_wr_dw),
    .wr_be(cfg_wr_be), .wr_data(cfg_wr_data), .bar_q(bar_q)
  );

  ecw_field_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_dec (
    .bar(bar_q[ADDR_W-1:0]), .en(win_en), .base(win_base), .len(win_len)
  );

  ecw_addr_match #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_match (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .en(win_en), .base(win_base), .len(win_len),
    .hit_valid_q(hit_valid), .hit_q(hit), .off_q(off_q)
  );

  always_comb begin
    bar_value = bar_q;
    hit_bus   = off_q[WIN_LOG2-1:20];
    hit_dev   = off_q[19:15];
    hit_fn    = off_q[14:12];
    hit_reg   = off_q[11:0];
  end
endmodule

// File: rtl/ecw_window_chk.sv
module ecw_window_chk #(
  parameter int ADDR_W   = 36,
  parameter int WIN_LOG2 = 28,
  parameter int CFG_DW_W = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr_en,
  input logic [CFG_DW_W-1:0]  cfg_wr_dw,
  input logic [63:0]          bar_value,
  input logic                 win_en,
  input logic [ADDR_W-1:0]    win_base,
  input logic [WIN_LOG2:0]    win_len,
  input logic                 mem_valid,
  input logic                 hit_valid,
  input logic                 hit,
  input logic [WIN_LOG2-21:0] hit_bus,
  input logic [4:0]           hit_dev,
  input logic [2:0]           hit_fn,
  input logic [11:0]          hit_reg
);
  localparam logic [CFG_DW_W-1:0] DW_LO = CFG_DW_W'(6'h18);
  localparam logic [CFG_DW_W-1:0] DW_HI = CFG_DW_W'(6'h19);

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(bar_value));

  p_other_dw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_dw != DW_LO && cfg_wr_dw != DW_HI) |=> $stable(bar_value));

  p_off_when_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !win_en) |=> !hit);

  p_len_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_len));

  p_base_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_base[WIN_LOG2-4:0] == '0);

  p_reserved_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_value[2:1] == 2'b11) |-> (!win_en && win_len == '0));

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |=> hit_valid);

  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |=> !hit_valid);

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit) |-> (hit_bus == '0 && hit_dev == '0 && hit_fn == '0 && hit_reg == '0));
endmodule

bind ecw_window_dec ecw_window_chk #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .CFG_DW_W(CFG_DW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw),
  .bar_value(bar_value), .win_en(win_en), .win_base(win_base), .win_len(win_len),
  .mem_valid(mem_valid), .hit_valid(hit_valid), .hit(hit), .hit_bus(hit_bus),
  .hit_dev(hit_dev), .hit_fn(hit_fn), .hit_reg(hit_reg)
);

// File: tb/ecw_window_dec_tb.sv
`timescale 1ns/1ps
module ecw_window_dec_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [5:0]  cfg_wr_dw;
  logic [3:0]  cfg_wr_be;
  logic [31:0] cfg_wr_data;
  logic [63:0] bar_value;
  logic        win_en;
  logic [35:0] win_base;
  logic [28:0] win_len;
  logic        mem_valid;
  logic [35:0] mem_addr;
  logic        hit_valid;
  logic        hit;
  logic [7:0]  hit_bus;
  logic [4:0]  hit_dev;
  logic [2:0]  hit_fn;
  logic [11:0] hit_reg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  ecw_window_dec dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw),
    .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data), .bar_value(bar_value),
    .win_en(win_en), .win_base(win_base), .win_len(win_len),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .hit_valid(hit_valid), .hit(hit),
    .hit_bus(hit_bus), .hit_dev(hit_dev), .hit_fn(hit_fn), .hit_reg(hit_reg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [63:0] regv;
    logic [35:0] addr;
    logic        exp_hit;
    logic [27:0] exp_off;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_B000_0001, 36'h0_B000_0000, 1'b1, 28'h000_0000},
    '{64'h0000_0000_B000_0001, 36'h0_BFFF_FFFF, 1'b1, 28'hFFF_FFFF},
    '{64'h0000_0000_B000_0001, 36'h0_C000_0000, 1'b0, 28'h0},
    '{64'h0000_0000_B000_0001, 36'h0_AFFF_FFFF, 1'b0, 28'h0},
    '{64'h0000_0000_E000_0003, 36'h0_E7FF_FFFF, 1'b1, 28'h7FF_FFFF},
    '{64'h0000_0000_E000_0003, 36'h0_E800_0000, 1'b0, 28'h0},
    '{64'h0000_0000_E600_0005, 36'h0_E612_3456, 1'b1, 28'h012_3456},
    '{64'h0000_0000_E600_0005, 36'h0_EA00_0000, 1'b0, 28'h0},
    '{64'h0000_0000_E7FF_FFF5, 36'h0_E600_0010, 1'b1, 28'h000_0010},
    '{64'h0000_000F_B000_0001, 36'hF_B000_0040, 1'b1, 28'h000_0040},
    '{64'h0000_000F_B000_0001, 36'h0_B000_0040, 1'b0, 28'h0},
    '{64'h0000_0000_B000_0007, 36'h0_B000_0000, 1'b0, 28'h0},
    '{64'h0000_0000_B000_0000, 36'h0_B000_0100, 1'b0, 28'h0},
    '{64'h0000_0000_2400_0003, 36'h0_2BFF_FFFF, 1'b1, 28'h7FF_FFFF},
    '{64'h0000_0000_2400_0003, 36'h0_23FF_FFFF, 1'b0, 28'h0},
    '{64'hFFFF_FFF0_0000_0001, 36'h0_0000_0100, 1'b1, 28'h000_0100}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_dw = dw; cfg_wr_be = be; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_be = 4'h0;
  endtask

  task automatic load_bar(input logic [63:0] v);
    cfg_write(6'h18, 4'hF, v[31:0]);
    cfg_write(6'h19, 4'hF, v[63:32]);
  endtask

  task automatic probe(input logic [35:0] a);
    @(negedge clk);
    mem_valid = 1'b1; mem_addr = a;
    @(negedge clk);
    mem_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_dw = '0; cfg_wr_be = '0; cfg_wr_data = '0;
    mem_valid = 1'b0; mem_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(bar_value == 64'h0000_0000_B000_0000, "R1 reset register", bar_value, 64'hB000_0000);
    check(win_en == 1'b0, "R1 reset enable", 64'(win_en), 64'h0);
    check(win_base == 36'hB000_0000, "R1 reset base", 64'(win_base), 64'hB000_0000);
    check(win_len == 29'h1000_0000, "R1 reset length", 64'(win_len), 64'h1000_0000);
    check(hit_valid == 1'b0 && hit == 1'b0, "R1 reset hit outputs", 64'({hit_valid, hit}), 64'h0);

    // R7 / R3: disabled window after reset gives no hit
    probe(36'h0_B000_0000);
    check(hit_valid == 1'b1, "R7 hit_valid follows mem_valid", 64'(hit_valid), 64'h1);
    check(hit == 1'b0, "R3 disabled window misses", 64'(hit), 64'h0);
    @(negedge clk);
    check(hit_valid == 1'b0, "R7 hit_valid drops", 64'(hit_valid), 64'h0);

    // Vector table: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      load_bar(VECS[i].regv);
      probe(VECS[i].addr);
      check(hit == VECS[i].exp_hit, $sformatf("R7 hit vector %0d", i), 64'(hit), 64'(VECS[i].exp_hit));
      check({hit_bus, hit_dev, hit_fn, hit_reg} == VECS[i].exp_off,
            $sformatf("R8 offset fields vector %0d", i),
            64'({hit_bus, hit_dev, hit_fn, hit_reg}), 64'(VECS[i].exp_off));
    end

    // R8 field split check on a known offset
    load_bar(64'h0000_0000_E600_0005);
    probe(36'h0_E612_3456);
    check(hit_bus == 8'h01 && hit_dev == 5'd4 && hit_fn == 3'd3 && hit_reg == 12'h456,
          "R8 bus/dev/fn/reg split", 64'({hit_bus, hit_dev, hit_fn, hit_reg}), 64'({8'h01, 5'd4, 3'd3, 12'h456}));

    // R4 / R6 length codes
    load_bar(64'h0000_0000_0000_0003);
    check(win_len == 29'h0800_0000 && win_en, "R4 code 01 length", 64'(win_len), 64'h0800_0000);
    load_bar(64'h0000_0000_0000_0005);
    check(win_len == 29'h0400_0000 && win_en, "R4 code 10 length", 64'(win_len), 64'h0400_0000);
    load_bar(64'h0000_0000_0000_0001);
    check(win_len == 29'h1000_0000 && win_en, "R4 code 00 length", 64'(win_len), 64'h1000_0000);
    load_bar(64'h0000_0000_0000_0007);
    check(win_len == 29'h0 && !win_en, "R6 reserved code off", 64'({win_en, win_len}), 64'h0);

    // R5 base masking per code
    load_bar(64'h0000_0003_FFFF_FFF3);
    check(win_base == 36'h3_FC00_0000, "R5 base 128MB mask", 64'(win_base), 64'h3_FC00_0000);
    load_bar(64'h0000_0003_FFFF_FFF5);
    check(win_base == 36'h3_FE00_0000, "R5 base 64MB mask", 64'(win_base), 64'h3_FE00_0000);
    load_bar(64'h0000_0003_FFFF_FFF1);
    check(win_base == 36'h3_F000_0000, "R5 base 256MB mask", 64'(win_base), 64'h3_F000_0000);

    // R2 byte-lane writes
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    cfg_write(6'h18, 4'b0010, 32'h1234_AB56);
    check(bar_value == 64'h0000_0000_B000_AB00, "R2 single byte lane", bar_value, 64'hB000_AB00);
    cfg_write(6'h19, 4'b1000, 32'h1200_0000);
    check(bar_value == 64'h1200_0000_B000_AB00, "R2 upper dword lane", bar_value, 64'h1200_0000_B000_AB00);
    cfg_write(6'h17, 4'hF, 32'hFFFF_FFFF);
    check(bar_value == 64'h1200_0000_B000_AB00, "R2 other dword ignored", bar_value, 64'h1200_0000_B000_AB00);
    cfg_write(6'h1A, 4'hF, 32'hFFFF_FFFF);
    check(bar_value == 64'h1200_0000_B000_AB00, "R2 next dword ignored", bar_value, 64'h1200_0000_B000_AB00);
    cfg_write(6'h18, 4'b0000, 32'hFFFF_FFFF);
    check(bar_value == 64'h1200_0000_B000_AB00, "R2 empty byte enables", bar_value, 64'h1200_0000_B000_AB00);
    cfg_write(6'h18, 4'b0001, 32'h0000_0001);
    check(win_en == 1'b1 && win_base == 36'hB000_0000, "R2 decode follows write", 64'(win_base), 64'hB000_0000);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule